// File: doc/BRIEF.md
# Interrupt running priority tracker

This block keeps the set of interrupt priority levels that are currently active on one CPU interface and reports the running priority, meaning the group priority of the most urgent active interrupt whose priority has not yet been dropped. An acknowledge event marks a level active. It carries an 8-bit priority, an NMI flag and a security tag. A priority-drop event retires whichever source is currently running. A combinational read port takes the reader's security state and returns a 64-bit status word. The word holds the running priority in its low byte and two NMI indicator bits at the top.

Priorities are reported at the minimum binary point, so the lowest priority bit is discarded and each group covers two raw priority values. NMIs do not use the priority they were acknowledged with. A Secure NMI, or any NMI while a single security state is configured, runs at 0x00. A Non-secure NMI runs at 0x80. A Non-secure reader sees that value saturated to 0x00. The running source is one of four classes: SRC_IDLE (nothing active), SRC_LEVEL (a maskable level), SRC_SNMI and SRC_NSNMI. Acknowledge moves the running source towards a more urgent class or level. Drop moves it to the next active source, or to SRC_IDLE when nothing is left.

Top module: `rpt_running_prio`

## Requirements
- R1: The read word's bits [7:0] give the group priority of the active source with the lowest group value. A maskable level acknowledged with priority p has group value {p[7:1],0}.
- R2: After reset, and whenever no source remains active, bits [7:0] read 0xFF for both reader states.
- R3: Two priorities that differ only in bit 0 select the same level, and bit 0 of the reported priority is always 0 unless the value is idle 0xFF.
- R4: An NMI acknowledged with ack_ns=0, or with single_sec=1, becomes active at group value 0x00 and sets bit 63 of the read word while it stays active.
- R5: An NMI acknowledged with ack_ns=1 and single_sec=0 is active at group value 0x80. While it is the running source, a secure read (rd_ns=0) reports 0x80 and a Non-secure read (rd_ns=1) reports 0x00. Bit 62 reads 1 while it is active for rd_ns=0, and 0 for rd_ns=1.
- R6: A drop clears exactly the running source, the one with the lowest group value. At an equal group value an NMI goes before a maskable level. A drop with nothing active changes nothing.
- R7: When acknowledge and drop occur in the same cycle, the drop is applied to the prior state first and the acknowledge afterwards.
- R8: Bits [61:8] of the read word always read 0.
- R9: Acknowledging a level that is already active does not stack: one drop retires it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all active state |
| single_sec | input | 1 | 1 when only one security state is configured |
| ack_valid | input | 1 | Acknowledge event this cycle |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_nmi | input | 1 | Acknowledged interrupt is an NMI |
| ack_ns | input | 1 | Acknowledged interrupt is Non-secure Group 1 |
| drop_valid | input | 1 | Priority-drop event this cycle |
| rd_ns | input | 1 | Reader is Non-secure |
| rd_data | output | 64 | Running priority status word |

## Verification
Acknowledge and priority drop can fall in the same cycle, and the result depends on which one is applied first. The bench drives both together in directed cases: a drop of a Secure NMI combined with a new acknowledge of an already-active level, and a drop and re-acknowledge of the only active level, which must leave that level running. It also produces many such collisions randomly. Each outcome is judged against a bench model that applies the drop before the acknowledge. The status word is compared for both reader states after every cycle.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    // Class of the source that currently sets the running priority
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_LEVEL = 2'd1,
        SRC_SNMI  = 2'd2,
        SRC_NSNMI = 2'd3
    } run_src_e;

endpackage

// File: rtl/rpt_prio_scan.sv
module rpt_prio_scan #(
    parameter int N = 128,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Lowest set index wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/rpt_active_store.sv
module rpt_active_store
    import rpt_pkg::*;
#(
    parameter int PRIO_W = 8,
    localparam int IDX_W  = PRIO_W - 1,
    localparam int LEVELS = 1 << IDX_W,
    localparam int NS_IDX = LEVELS / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             single_sec,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_grp,
    input  logic             ack_nmi,
    input  logic             ack_ns,
    input  logic             drop_valid,
    output run_src_e         src,
    output logic [IDX_W-1:0] lvl_idx,
    output logic             snmi_act,
    output logic             nsnmi_act
);

    logic [LEVELS-1:0] lvl_q, lvl_d;
    logic              snmi_q, snmi_d;
    logic              nsnmi_q, nsnmi_d;
    logic              lvl_any;

    rpt_prio_scan #(.N(LEVELS)) u_scan (
        .vec (lvl_q),
        .any (lvl_any),
        .idx (lvl_idx)
    );

    // Running source classification
    always_comb begin
        if (snmi_q)
            src = SRC_SNMI;
        else if (nsnmi_q && (!lvl_any || lvl_idx >= IDX_W'(NS_IDX)))
            src = SRC_NSNMI;
        else if (lvl_any)
            src = SRC_LEVEL;
        else
            src = SRC_IDLE;
    end

    // Next state: drop first, then acknowledge
    always_comb begin
        lvl_d   = lvl_q;
        snmi_d  = snmi_q;
        nsnmi_d = nsnmi_q;
        if (drop_valid) begin
            unique case (src)
                SRC_SNMI:  snmi_d = 1'b0;
                SRC_NSNMI: nsnmi_d = 1'b0;
                SRC_LEVEL: lvl_d[lvl_idx] = 1'b0;
                SRC_IDLE:  ;
            endcase
        end
        if (ack_valid) begin
            if (ack_nmi) begin
                if (single_sec || !ack_ns)
                    snmi_d = 1'b1;
                else
                    nsnmi_d = 1'b1;
            end else begin
                lvl_d[ack_grp] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            snmi_q  <= 1'b0;
            nsnmi_q <= 1'b0;
        end else begin
            lvl_q   <= lvl_d;
            snmi_q  <= snmi_d;
            nsnmi_q <= nsnmi_d;
        end
    end

    assign snmi_act  = snmi_q;
    assign nsnmi_act = nsnmi_q;

endmodule

// File: rtl/rpt_read_fmt.sv
module rpt_read_fmt
    import rpt_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int DATA_W = 64,
    localparam int IDX_W = PRIO_W - 1
) (
    input  run_src_e          src,
    input  logic [IDX_W-1:0]  lvl_idx,
    input  logic              snmi_act,
    input  logic              nsnmi_act,
    input  logic              rd_ns,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [PRIO_W-1:0] IDLE_PRIO  = '1;
    localparam logic [PRIO_W-1:0] NSNMI_PRIO = PRIO_W'(1) << (PRIO_W - 1);

    logic [PRIO_W-1:0] prio;

    always_comb begin
        unique case (src)
            SRC_IDLE:  prio = IDLE_PRIO;
            SRC_LEVEL: prio = {lvl_idx, 1'b0};
            SRC_SNMI:  prio = '0;
            SRC_NSNMI: prio = rd_ns ? '0 : NSNMI_PRIO;
        endcase
    end

    always_comb begin
        rd_data               = '0;
        rd_data[PRIO_W-1:0]   = prio;
        rd_data[DATA_W-1]     = snmi_act;
        rd_data[DATA_W-2]     = nsnmi_act & ~rd_ns;
    end

endmodule

// File: rtl/rpt_running_prio.sv
module rpt_running_prio
    import rpt_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_sec,
    input  logic              ack_valid,
    input  logic [PRIO_W-1:0] ack_prio,
    input  logic              ack_nmi,
    input  logic              ack_ns,
    input  logic              drop_valid,
    input  logic              rd_ns,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = PRIO_W - 1;

    run_src_e         src;
    logic [IDX_W-1:0] lvl_idx;
    logic             snmi_act;
    logic             nsnmi_act;
    logic             prio_lsb_unused;

    // Minimum binary point: the lowest priority bit is not part of the group
    assign prio_lsb_unused = ack_prio[0];

    rpt_active_store #(.PRIO_W(PRIO_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .single_sec (single_sec),
        .ack_valid  (ack_valid),
        .ack_grp    (ack_prio[PRIO_W-1:1]),
        .ack_nmi    (ack_nmi),
        .ack_ns     (ack_ns),
        .drop_valid (drop_valid),
        .src        (src),
        .lvl_idx    (lvl_idx),
        .snmi_act   (snmi_act),
        .nsnmi_act  (nsnmi_act)
    );

    rpt_read_fmt #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_fmt (
        .src       (src),
        .lvl_idx   (lvl_idx),
        .snmi_act  (snmi_act),
        .nsnmi_act (nsnmi_act),
        .rd_ns     (rd_ns),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/rpt_running_prio_chk.sv
module rpt_running_prio_chk #(
    parameter int PRIO_W = 8,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_valid,
    input logic              drop_valid,
    input logic              rd_ns,
    input logic [DATA_W-1:0] rd_data
);

    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-3:PRIO_W] == '0); // R8

    AST_GROUP_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[PRIO_W-1:0] != IDLE_PRIO) |-> !rd_data[0]); // R3

    AST_NS_HIDES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ns |-> !rd_data[DATA_W-2]); // R5

    AST_SNMI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1] |-> (rd_data[PRIO_W-1:0] == '0)); // R4

    AST_ACK_LEAVES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (rd_data[PRIO_W-1:0] != IDLE_PRIO)); // R7

    AST_DROP_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_valid && !ack_valid && rd_data[PRIO_W-1:0] == IDLE_PRIO && !rd_data[DATA_W-1] && !rd_data[DATA_W-2] && !rd_ns)
        |=> (rd_data[PRIO_W-1:0] == IDLE_PRIO)); // R6

endmodule

bind rpt_running_prio rpt_running_prio_chk #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_valid  (ack_valid),
    .drop_valid (drop_valid),
    .rd_ns      (rd_ns),
    .rd_data    (rd_data)
);

// File: tb/rpt_running_prio_bench.sv
`timescale 1ns/1ps
module rpt_running_prio_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        single_sec = 1'b0;
    logic        ack_valid = 1'b0;
    logic [7:0]  ack_prio = '0;
    logic        ack_nmi = 1'b0;
    logic        ack_ns = 1'b0;
    logic        drop_valid = 1'b0;
    logic        rd_ns = 1'b0;
    logic [63:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model of the active state
    bit [127:0] m_lvl;
    bit         m_s;
    bit         m_n;

    always #4 clk = ~clk;

    rpt_running_prio u_rpt_running_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .single_sec (single_sec),
        .ack_valid  (ack_valid),
        .ack_prio   (ack_prio),
        .ack_nmi    (ack_nmi),
        .ack_ns     (ack_ns),
        .drop_valid (drop_valid),
        .rd_ns      (rd_ns),
        .rd_data    (rd_data)
    );

    function automatic int m_lowest();
        int lo = -1;
        for (int i = 127; i >= 0; i--) if (m_lvl[i]) lo = i;
        return lo;
    endfunction

    function automatic bit m_ns_runs();
        int lo = m_lowest();
        return !m_s && m_n && (lo < 0 || lo >= 64);
    endfunction

    // R6: retire the source with the lowest group value, NMI first on ties
    function automatic void m_drop();
        int lo = m_lowest();
        if (m_s) m_s = 1'b0;
        else if (m_ns_runs()) m_n = 1'b0;
        else if (lo >= 0) m_lvl[lo] = 1'b0;
    endfunction

    function automatic void m_ack(bit [7:0] p, bit nmi, bit ns);
        if (nmi) begin
            if (single_sec || !ns) m_s = 1'b1;
            else m_n = 1'b1;
        end else m_lvl[p[7:1]] = 1'b1;
    endfunction

    function automatic logic [63:0] m_word(bit ns);
        logic [63:0] w = '0;
        int lo = m_lowest();
        if (m_s) w[7:0] = 8'h00;
        else if (m_ns_runs()) w[7:0] = ns ? 8'h00 : 8'h80;
        else if (lo >= 0) w[7:0] = 8'(lo * 2);
        else w[7:0] = 8'hFF;
        w[63] = m_s;
        w[62] = m_n & ~ns;
        return w;
    endfunction

    function automatic string auto_tag();
        if (m_s) return "R4";
        if (m_ns_runs()) return "R5";
        if (m_lowest() >= 0) return "R1";
        return "R2";
    endfunction

    task automatic check_reads(string tag);
        string t;
        logic [63:0] exp;
        for (int k = 0; k < 2; k++) begin
            rd_ns = k[0];
            #1;
            exp = m_word(k[0]);
            t = (tag == "") ? auto_tag() : tag;
            n_checks++;
            if (rd_data !== exp) begin
                n_fails++;
                $display("FAIL %s rd_ns=%0d actual=%h expected=%h", t, k, rd_data, exp);
            end
            n_checks++;
            if (rd_data[61:8] !== '0) begin
                n_fails++;
                $display("FAIL R8 reserved bits actual=%h expected=0", rd_data[61:8]);
            end
        end
        rd_ns = 1'b0;
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic do_cycle(bit a, bit [7:0] p, bit nmi, bit ns, bit d, string tag);
        ack_valid  = a;
        ack_prio   = p;
        ack_nmi    = nmi;
        ack_ns     = ns;
        drop_valid = d;
        @(posedge clk);
        if (d) m_drop();      // R7: drop applied before acknowledge
        if (a) m_ack(p, nmi, ns);
        #1;
        ack_valid  = 1'b0;
        drop_valid = 1'b0;
        check_reads(tag);
        @(negedge clk);
    endtask

    task automatic do_reset(bit ss);
        @(negedge clk);
        rst_n = 1'b0;
        single_sec = ss;
        m_lvl = '0;
        m_s = 1'b0;
        m_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_reads("R2");
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);

        // R3, R9: odd and even priority share a level, no stacking
        do_cycle(1, 8'h45, 0, 0, 0, "R3");
        do_cycle(1, 8'h44, 0, 1, 0, "R9");
        do_cycle(0, 8'h00, 0, 0, 1, "R9");
        do_cycle(0, 8'h00, 0, 0, 1, "R6");

        // R5, R6: Non-secure NMI ties with level 0x80 and goes first
        do_cycle(1, 8'h81, 0, 1, 0, "R1");
        do_cycle(1, 8'h10, 1, 1, 0, "R5");
        do_cycle(0, 8'h00, 0, 0, 1, "R6");
        do_cycle(0, 8'h00, 0, 0, 1, "R2");

        // R1, R5: a more urgent level hides the Non-secure NMI value
        do_cycle(1, 8'h20, 0, 0, 0, "R1");
        do_cycle(1, 8'hF0, 1, 1, 0, "R5");
        do_cycle(0, 8'h00, 0, 0, 1, "R6");
        do_cycle(0, 8'h00, 0, 0, 1, "R6");

        // R4, R7: Secure NMI, then drop and acknowledge together
        do_cycle(1, 8'h10, 0, 0, 0, "R1");
        do_cycle(1, 8'h77, 1, 0, 0, "R4");
        do_cycle(1, 8'h11, 0, 0, 1, "R7");
        do_cycle(1, 8'h10, 0, 0, 1, "R7");
        do_cycle(0, 8'h00, 0, 0, 1, "R2");
        do_cycle(0, 8'h00, 0, 0, 1, "R6");

        // R4: single security state makes every NMI a 0x00 NMI
        do_reset(1'b1);
        do_cycle(1, 8'h33, 1, 1, 0, "R4");
        do_cycle(1, 8'hFF, 0, 1, 0, "R4");
        do_cycle(0, 8'h00, 0, 0, 1, "R3");

        // Random mix with frequent acknowledge/drop collisions
        do_reset(1'b0);
        for (int n = 0; n < 3000; n++) begin
            bit a   = ($urandom_range(0, 99) < 50);
            bit d   = ($urandom_range(0, 99) < 45);
            bit nmi = ($urandom_range(0, 7) == 0);
            bit ns  = $urandom_range(0, 1);
            bit [7:0] p = 8'($urandom_range(0, 255));
            do_cycle(a, p, nmi, ns, d, "");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule